// File: doc/BRIEF.md
# LED Activity Combiner with Pulse Stretcher

This block drives a single LED pin from a group of status lines. Every status line has its own enable bit. Only enabled lines take part, and any one of them being high marks the cycle as active. The active indication feeds a short pulse stretcher, so even a one-clock event gives a blink long enough to see.

The stretcher is a chain of stages that is filled with ones on any active clock cycle. It shifts zeros in only when a slow tick strobe arrives; the intended tick is about 38 Hz, which is one step every 26 ms. With the default depth of three stages, the LED stays lit for two to three tick periods after the last activity, which is roughly 52 to 78 ms. The pin is active low by default. A polarity input flips the pin so that it is active high.

The status events, the register access that sets the enables and the pad driver all sit outside the block. The tick comes from an external prescaler as a one-clock strobe.

Top module: `led_activity_stretcher`

## Requirements
- R1: A status bit whose enable bit is 0 has no effect. With all enables cleared, or with status high only on disabled positions, the LED stays off.
- R2: A single enabled status bit at any position n (enable[n]=1, status[n]=1) is enough to light the LED. Every position is treated the same way.
- R3: After any clock cycle with enabled activity, the LED is lit in the following cycle. This does not depend on the tick.
- R4: When activity and tick are high in the same cycle, the stretcher is refilled and does not shift.
- R5: With no activity and no tick, the stretcher state and the LED do not change.
- R6: After the last activity, the LED stays lit through STAGES-1 tick strobes. It goes off on the cycle after the STAGES-th tick strobe (the third tick by default).
- R7: With pol_high=0 the pin is 0 while lit and 1 while off. With pol_high=1 the pin is 1 while lit and 0 while off.
- R8: A clock edge with rst_n=0 empties the stretcher, so the LED is off after it. This includes reset in the middle of a stretch.
- R9: Activity during a stretch refills it, so the full STAGES-tick hold restarts from that activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock slow shift strobe (about 38 Hz) |
| status | input | N_SRC | Status event lines |
| enable | input | N_SRC | Per-line enable bits |
| pol_high | input | 1 | 1 = active-high pin, 0 = active-low pin |
| led_o | output | 1 | LED pin |

## Verification
The assertions assume that tick is a single-clock strobe sampled on the system clock. They also assume that pol_high changes only between clock edges like any other synchronous input, so the lit state recovered from the pin and the polarity stays meaningful across cycles. The stimulus holds each input for exactly one clock and changes it only on the falling edge. It raises tick for one cycle at a time and places idle cycles between ticks. It also stacks activity, tick and reset into the same cycle to reach the priority cases.

// File: rtl/led_stretch_pkg.sv
// Package: shared defaults for the LED activity stretcher.
// Assumes: nothing; constants only.
package led_stretch_pkg;
    localparam int LED_DEF_SRCS   = 7;  // status lines per LED
    localparam int LED_DEF_STAGES = 3;  // stretcher depth in ticks
endpackage

// File: rtl/led_src_merge.sv
// Module: gates each status line with its enable and merges the results.
// Assumes: status and enable are synchronous to the system clock.
module led_src_merge #(
    parameter int N_SRC = 7
) (
    input  logic [N_SRC-1:0] status,
    input  logic [N_SRC-1:0] enable,
    output logic             any_act
);
    logic [N_SRC-1:0] gated;

    // Per-line qualification by its own enable bit.
    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        assign gated[g] = status[g] & enable[g];
    end

    // Merge every qualified line into one activity flag.
    assign any_act = |gated;
endmodule

// File: rtl/led_pulse_stretch.sv
// Module: stage chain filled with ones on activity; zeros shift in on tick.
// Assumes: STAGES >= 2; tick is a one-clock strobe; active-low sync reset.
module led_pulse_stretch #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_all,
    input  logic              tick,
    output logic [STAGES-1:0] stage_o,
    output logic              lit
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    // Reset clears; activity presets; the tick shifts a zero in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (set_all) begin
            chain_q <= '1;
        end else if (tick) begin
            chain_q <= {chain_q[LAST-1:0], 1'b0};
        end
    end

    // The last stage decides whether the LED is lit.
    assign lit     = chain_q[LAST];
    assign stage_o = chain_q;
endmodule

// File: rtl/led_pin_drive.sv
// Module: maps the lit state to the pin level under polarity select.
// Assumes: pol_high is quasi-static and synchronous to the system clock.
module led_pin_drive (
    input  logic lit,
    input  logic pol_high,
    output logic pin
);
    // Active-low by default; pol_high flips to active-high.
    always_comb begin
        if (pol_high) pin = lit;
        else          pin = ~lit;
    end
endmodule

// File: rtl/led_activity_stretcher.sv
// Module: top level; enable gating, merge, pulse stretcher, pin polarity.
// Assumes: tick is a one-clock strobe from an external prescaler.
module led_activity_stretcher
    import led_stretch_pkg::*;
#(
    parameter int N_SRC  = LED_DEF_SRCS,
    parameter int STAGES = LED_DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [N_SRC-1:0] status,
    input  logic [N_SRC-1:0] enable,
    input  logic             pol_high,
    output logic             led_o
);
    logic              act;
    logic              lit;
    logic [STAGES-1:0] stage_q;

    led_src_merge #(.N_SRC(N_SRC)) u_merge (
        .status  (status),
        .enable  (enable),
        .any_act (act)
    );

    led_pulse_stretch #(.STAGES(STAGES)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_all (act),
        .tick    (tick),
        .stage_o (stage_q),
        .lit     (lit)
    );

    led_pin_drive u_drive (
        .lit      (lit),
        .pol_high (pol_high),
        .pin      (led_o)
    );
endmodule

// File: rtl/led_activity_stretcher_chk.sv
// Module: property checker bound to the top; observes ports and stage state.
// Assumes: inputs change only between clock edges.
module led_activity_stretcher_chk #(
    parameter int N_SRC  = 7,
    parameter int STAGES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [N_SRC-1:0]  status,
    input logic [N_SRC-1:0]  enable,
    input logic              pol_high,
    input logic              led_o,
    input logic [STAGES-1:0] stage_q
);
    logic act_w;
    logic lit_w;

    // Activity and lit state recovered independently from the ports.
    assign act_w = |(status & enable);
    assign lit_w = pol_high ? led_o : ~led_o;

    AST_SET_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        act_w |=> lit_w);                                              // R3
    AST_PRESET_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (act_w && tick) |=> (stage_q == '1));                           // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_w && !tick) |=> ($stable(stage_q) && $stable(lit_w)));    // R5
    AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_w && tick) |=> (stage_q[0] == 1'b0 &&
                              stage_q[STAGES-1:1] == $past(stage_q[STAGES-2:0]))); // R6
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_w && stage_q == '0) |=> !lit_w);                           // R1
    AST_RESET_DARK: assert property (@(posedge clk)
        !rst_n |=> (stage_q == '0));                                    // R8
endmodule

bind led_activity_stretcher led_activity_stretcher_chk #(
    .N_SRC  (N_SRC),
    .STAGES (STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .status   (status),
    .enable   (enable),
    .pol_high (pol_high),
    .led_o    (led_o),
    .stage_q  (stage_q)
);

// File: tb/tb_led_activity_stretcher.sv
// Bench: scoreboard; driver pushes expected pin levels, monitor compares.
module tb_led_activity_stretcher;
    localparam int N  = 7;
    localparam int ST = 3;

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [N-1:0] status = '0;
    logic [N-1:0] enable = '0;
    logic         pol_high = 1'b0;
    logic         led_o;

    item_t q[$];
    int    checks = 0;
    int    fails = 0;
    int    remain = 0;   // ticks left before the LED goes dark
    bit    done = 0;

    always #2.5 clk = ~clk;

    led_activity_stretcher #(.N_SRC(N), .STAGES(ST)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .status(status),
        .enable(enable), .pol_high(pol_high), .led_o(led_o)
    );

    // Driver: apply one cycle of inputs and push the expected pin level.
    task automatic drive(input logic [N-1:0] st, input logic [N-1:0] en,
                         input logic tk, input logic pol, input logic rs,
                         input string req);
        item_t it;
        @(negedge clk);
        status = st; enable = en; tick = tk; pol_high = pol; rst_n = rs;
        if (!rs)                   remain = 0;
        else if (|(st & en))       remain = ST;
        else if (tk && remain > 0) remain = remain - 1;
        it.exp = pol ? (remain > 0) : !(remain > 0);
        it.req = req;
        q.push_back(it);
    endtask

    task automatic idle(input int n, input logic pol, input string req);
        for (int i = 0; i < n; i++) drive('0, '1, 1'b0, pol, 1'b1, req);
    endtask

    task automatic tk1(input logic pol, input string req);
        drive('0, '1, 1'b1, pol, 1'b1, req);
        idle(2, pol, req);
    endtask

    // Monitor: compare after each rising edge once outputs settle.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (led_o !== it.exp) begin
                    fails++;
                    $display("FAIL %s led_o=%b expected=%b t=%0t",
                             it.req, led_o, it.exp, $time);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired checks=%0d expected completion", checks);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: reset state, pin high (off) with active-low polarity
        repeat (3) drive('0, '0, 1'b0, 1'b0, 1'b0, "R8");
        // R1: all status high but no enables; then status only on disabled lines
        repeat (3) drive('1, '0, 1'b1, 1'b0, 1'b1, "R1");
        drive(7'b0001111, 7'b1110000, 1'b0, 1'b0, 1'b1, "R1");
        drive(7'b1010101, 7'b0101010, 1'b1, 1'b0, 1'b1, "R1");
        // R2/R3/R6: each position alone, one-cycle event, then drain by ticks
        for (int i = 0; i < N; i++) begin
            drive(7'(1) << i, 7'(1) << i, 1'b0, 1'b0, 1'b1, "R2");
            idle(2, 1'b0, "R3");
            for (int t = 0; t < ST; t++) tk1(1'b0, "R6");
        end
        // R5: long hold without tick keeps LED lit
        drive(7'b0000100, '1, 1'b0, 1'b0, 1'b1, "R3");
        idle(20, 1'b0, "R5");
        tk1(1'b0, "R5");
        idle(10, 1'b0, "R5");
        tk1(1'b0, "R6");
        tk1(1'b0, "R6");
        idle(4, 1'b0, "R5");
        // R4: activity with tick together refills, then drain
        drive(7'b0000001, 7'b0000001, 1'b1, 1'b0, 1'b1, "R4");
        for (int t = 0; t < ST; t++) tk1(1'b0, "R4");
        // R9: retrigger during stretch restarts full hold
        drive(7'b1000000, '1, 1'b0, 1'b0, 1'b1, "R9");
        tk1(1'b0, "R9");
        tk1(1'b0, "R9");
        drive(7'b0100000, '1, 1'b0, 1'b0, 1'b1, "R9");
        for (int t = 0; t < ST; t++) tk1(1'b0, "R9");
        // R7: active-high polarity, idle dark then event and drain
        idle(2, 1'b1, "R7");
        drive(7'b0010000, 7'b0010000, 1'b0, 1'b1, 1'b1, "R7");
        for (int t = 0; t < ST; t++) tk1(1'b1, "R7");
        // R8: reset mid-stretch, and reset beats activity
        drive(7'b0001000, '1, 1'b0, 1'b0, 1'b1, "R8");
        drive('0, '1, 1'b0, 1'b0, 1'b0, "R8");
        idle(2, 1'b0, "R8");
        drive('1, '1, 1'b1, 1'b1, 1'b0, "R8");
        idle(2, 1'b1, "R8");
        // drain the scoreboard
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule